// File: doc/BRIEF.md
# Segment Staging Write Buffer

This block takes over a memory write once the serial instruction and its address have been decoded. It sorts the start address into one of five regions: user memory, configuration registers, read-only space, volatile register space, or unmapped space. It then applies the protection rule that belongs to that region. For the two directly written regions (configuration and volatile registers) it only produces a permission level, which a separate path uses.

For a user-memory target, the block keeps a staging buffer the size of one segment. In the cycle after the start strobe, the buffer is loaded with the current contents of the addressed segment. Incoming bytes then overwrite it one lane at a time. The lane pointer starts at the low address bits and wraps inside the segment, so any run of 1 to 16 bytes, starting at any offset, replaces only the lanes it reaches. When chip select is released, the block issues a one-cycle commit request carrying the segment number and the whole buffer. It does so only if the write is permitted and at least one byte arrived.

Top module: `seg_wbuf`

## Requirements
- R1: After reset, `commit_vld` and `dir_wr_ok` are 0.
- R2: Buffer lanes that receive no byte during a session keep the segment contents present on `seg_rd_data` in the cycle after `start_vld`. `seg_rd_idx` holds the segment number, `start_addr[7:4]`, from that cycle on. Lane k is `seg_rd_data[8k+7:8k]`, and the same layout is used for `commit_data`.
- R3: The first data byte goes to lane `start_addr[3:0]`. Each later byte goes to the next lane up.
- R4: After lane 15 the pointer wraps to lane 0. A session of more than 16 bytes overwrites lanes that were written earlier in the same session.
- R5: A permitted commit raises `commit_vld` for exactly one cycle, in the cycle after the `cs_rise` cycle, with `commit_seg` = `start_addr[7:4]`. The byte accepted in the `cs_rise` cycle itself is included.
- R6: A session that ends with no byte received produces no commit.
- R7: `wen`, `prot_bp` and `rprot` are sampled with `start_vld`. When `wen` is 0, no commit occurs and `dir_wr_ok` is 0.
- R8: `prot_bp` selects the locked user segments: 00 locks none, 01 locks segments 12 to 15, 10 locks segments 8 to 15, 11 locks all 16. A write to a locked segment never commits.
- R9: For start addresses 100h to 10Fh, `dir_wr_ok` equals `wen`, whatever the protection bits are. No commit is issued.
- R10: For start addresses 110h to 11Fh and 136h to 1FFh, `dir_wr_ok` is 0 and no commit is issued.
- R11: For start addresses 120h to 135h, `dir_wr_ok` equals `wen AND NOT rprot`. No commit is issued.
- R12: A byte that arrives in the preload cycle is kept, taking priority over the preloaded value of its lane.
- R13: `dir_wr_ok` is set in the cycle after `start_vld` and cleared in the cycle after `cs_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Pulse: a write session begins at `start_addr` |
| start_addr | input | ADDR_W (9) | Decoded start address |
| byte_vld | input | 1 | A complete data byte is present |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse: chip select was released and the session ends |
| prot_bp | input | 2 | User-memory lock level |
| wen | input | 1 | Global write enable |
| rprot | input | 1 | Lock for the volatile register region |
| seg_rd_idx | output | 4 | Segment being preloaded |
| seg_rd_data | input | 128 | Current contents of segment `seg_rd_idx` |
| commit_vld | output | 1 | One-cycle commit request |
| commit_seg | output | 4 | Segment to program |
| commit_data | output | 128 | Full segment image to program |
| dir_wr_ok | output | 1 | Direct-region writes permitted for this session |

## Verification
The bench builds the block with its default parameters: a 9-bit address and 16 segments of 16 bytes. With these values every region boundary (0FFh/100h, 10Fh/110h, 11Fh/120h, 135h/136h) and every lock-level edge (segments 7/8 and 11/12) can be reached with single directed sessions. A 20-byte session starting at offset 14 wraps the pointer and overwrites lanes written earlier in the same session. Because the first byte of every session is sent in the preload cycle, the write-over-preload priority is exercised each time.

// File: rtl/seg_wbuf_pkg.sv
package seg_wbuf_pkg;
  typedef enum logic [2:0] {
    RG_USER  = 3'd0,
    RG_CFG   = 3'd1,
    RG_ROM   = 3'd2,
    RG_VOL   = 3'd3,
    RG_NONE  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRELOAD = 2'd1,
    ST_FILL    = 2'd2
  } wstate_e;
endpackage

// File: rtl/seg_wbuf_region.sv
module seg_wbuf_region
  import seg_wbuf_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int NUM_SEGS = 16,
  parameter int SEG_W    = 4,
  parameter logic [ADDR_W-1:0] USER_LAST = 'h0FF,
  parameter logic [ADDR_W-1:0] CFG_LAST  = 'h10F,
  parameter logic [ADDR_W-1:0] ROM_LAST  = 'h11F,
  parameter logic [ADDR_W-1:0] VOL_LAST  = 'h135
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEG_W-1:0]  seg,
  input  logic [1:0]        bp,
  input  logic              wen,
  input  logic              rprot,
  output region_e           region,
  output logic              buf_ok,
  output logic              dir_ok
);
  localparam int HALF_SEG    = NUM_SEGS / 2;
  localparam int QUARTER_SEG = NUM_SEGS - NUM_SEGS / 4;

  logic locked;

  always_comb begin
    if (addr <= USER_LAST)     region = RG_USER;
    else if (addr <= CFG_LAST) region = RG_CFG;
    else if (addr <= ROM_LAST) region = RG_ROM;
    else if (addr <= VOL_LAST) region = RG_VOL;
    else                       region = RG_NONE;
  end

  always_comb begin
    unique case (bp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (32'(seg) >= QUARTER_SEG);
      2'b10:   locked = (32'(seg) >= HALF_SEG);
      default: locked = 1'b1;
    endcase
  end

  always_comb begin
    buf_ok = (region == RG_USER) && wen && !locked;
    unique case (region)
      RG_CFG:  dir_ok = wen;
      RG_VOL:  dir_ok = wen && !rprot;
      default: dir_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/seg_wbuf_store.sv
module seg_wbuf_store #(
  parameter int SEG_BYTES = 16,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4
) (
  input  logic                          clk,
  input  logic                          ld_en,
  input  logic [SEG_BYTES*DATA_W-1:0]   ld_data,
  input  logic                          wr_en,
  input  logic [OFF_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [SEG_BYTES*DATA_W-1:0]   img
);
  for (genvar k = 0; k < SEG_BYTES; k++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_idx) == k))
        lane_q <= wr_data;
      else if (ld_en)
        lane_q <= ld_data[k*DATA_W +: DATA_W];
    end
    assign img[k*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/seg_wbuf.sv
module seg_wbuf
  import seg_wbuf_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SEG_BYTES = 16,
  parameter int NUM_SEGS  = 16,
  parameter int DATA_W    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start_vld,
  input  logic [ADDR_W-1:0]                     start_addr,
  input  logic                                  byte_vld,
  input  logic [DATA_W-1:0]                     byte_data,
  input  logic                                  cs_rise,
  input  logic [1:0]                            prot_bp,
  input  logic                                  wen,
  input  logic                                  rprot,
  output logic [$clog2(NUM_SEGS)-1:0]           seg_rd_idx,
  input  logic [SEG_BYTES*DATA_W-1:0]           seg_rd_data,
  output logic                                  commit_vld,
  output logic [$clog2(NUM_SEGS)-1:0]           commit_seg,
  output logic [SEG_BYTES*DATA_W-1:0]           commit_data,
  output logic                                  dir_wr_ok
);
  localparam int OFF_W = $clog2(SEG_BYTES);
  localparam int SEG_W = $clog2(NUM_SEGS);

  wstate_e          state_q;
  logic [OFF_W-1:0] ptr_q;
  logic [SEG_W-1:0] seg_q;
  logic             user_q, allow_q, got_q;

  region_e          rg;
  logic             rg_buf_ok, rg_dir_ok;
  logic [SEG_W-1:0] start_seg;
  logic             active, take_byte;

  assign start_seg = start_addr[OFF_W +: SEG_W];
  assign active    = (state_q != ST_IDLE);
  assign take_byte = active && user_q && byte_vld;

  seg_wbuf_region #(
    .ADDR_W   (ADDR_W),
    .NUM_SEGS (NUM_SEGS),
    .SEG_W    (SEG_W)
  ) u_region (
    .addr   (start_addr),
    .seg    (start_seg),
    .bp     (prot_bp),
    .wen    (wen),
    .rprot  (rprot),
    .region (rg),
    .buf_ok (rg_buf_ok),
    .dir_ok (rg_dir_ok)
  );

  seg_wbuf_store #(
    .SEG_BYTES (SEG_BYTES),
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W)
  ) u_store (
    .clk     (clk),
    .ld_en   (state_q == ST_PRELOAD),
    .ld_data (seg_rd_data),
    .wr_en   (take_byte),
    .wr_idx  (ptr_q),
    .wr_data (byte_data),
    .img     (commit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      seg_q      <= '0;
      user_q     <= 1'b0;
      allow_q    <= 1'b0;
      got_q      <= 1'b0;
      commit_vld <= 1'b0;
      dir_wr_ok  <= 1'b0;
    end else begin
      commit_vld <= 1'b0;
      if (start_vld) begin
        state_q   <= (rg == RG_USER) ? ST_PRELOAD : ST_FILL;
        ptr_q     <= start_addr[OFF_W-1:0];
        seg_q     <= start_seg;
        user_q    <= (rg == RG_USER);
        allow_q   <= rg_buf_ok;
        got_q     <= 1'b0;
        dir_wr_ok <= rg_dir_ok;
      end else if (active) begin
        if (take_byte) begin
          ptr_q <= ptr_q + 1'b1;
          got_q <= 1'b1;
        end
        if (cs_rise) begin
          state_q    <= ST_IDLE;
          dir_wr_ok  <= 1'b0;
          commit_vld <= user_q && allow_q && (got_q || take_byte);
        end else if (state_q == ST_PRELOAD) begin
          state_q <= ST_FILL;
        end
      end
    end
  end

  assign seg_rd_idx = seg_q;
  assign commit_seg = seg_q;
endmodule

// File: rtl/seg_wbuf_chk.sv
module seg_wbuf_chk #(
  parameter int ADDR_W = 9,
  parameter int SEG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_vld,
  input logic [ADDR_W-1:0] start_addr,
  input logic [1:0]        prot_bp,
  input logic              wen,
  input logic              cs_rise,
  input logic              commit_vld,
  input logic [SEG_W-1:0]  commit_seg,
  input logic              dir_wr_ok
);
  logic             ck_ok;
  logic [SEG_W-1:0] ck_seg;
  logic [SEG_W-1:0] s_seg;
  logic             s_free;

  assign s_seg = start_addr[7:4];
  always_comb begin
    case (prot_bp)
      2'b00:   s_free = 1'b1;
      2'b01:   s_free = (s_seg < 4'd12);
      2'b10:   s_free = (s_seg < 4'd8);
      default: s_free = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_ok  <= 1'b0;
      ck_seg <= '0;
    end else if (start_vld) begin
      ck_ok  <= (start_addr < ADDR_W'('h100)) && wen && s_free;
      ck_seg <= s_seg;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!commit_vld && !dir_wr_ok));

  // R5
  commit_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> $past(cs_rise));

  // R5
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit_vld |=> !commit_vld);

  // R5
  commit_seg_chk: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> (commit_seg == ck_seg));

  // R8
  commit_permit_chk: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> ck_ok);

  // R10
  rom_block_chk: assert property (@(posedge clk) disable iff (rst)
    (start_vld && (start_addr >= ADDR_W'('h110)) && (start_addr <= ADDR_W'('h11F)))
      |=> !dir_wr_ok);

  // R13
  dir_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !start_vld) |=> !dir_wr_ok);
endmodule

bind seg_wbuf seg_wbuf_chk #(.ADDR_W(ADDR_W), .SEG_W($clog2(NUM_SEGS))) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_vld  (start_vld),
  .start_addr (start_addr),
  .prot_bp    (prot_bp),
  .wen        (wen),
  .cs_rise    (cs_rise),
  .commit_vld (commit_vld),
  .commit_seg (commit_seg),
  .dir_wr_ok  (dir_wr_ok)
);

// File: tb/seg_wbuf_bench.sv
module seg_wbuf_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_vld = 1'b0;
  logic [8:0]   start_addr = '0;
  logic         byte_vld = 1'b0;
  logic [7:0]   byte_data = '0;
  logic         cs_rise = 1'b0;
  logic [1:0]   prot_bp = '0;
  logic         wen = 1'b0;
  logic         rprot = 1'b0;
  logic [3:0]   seg_rd_idx;
  logic [127:0] seg_rd_data;
  logic         commit_vld;
  logic [3:0]   commit_seg;
  logic [127:0] commit_data;
  logic         dir_wr_ok;

  int total = 0;
  int bad   = 0;
  logic [7:0] seg_mem [16][16];

  always #10 clk = ~clk;

  seg_wbuf u_seg_wbuf (
    .clk(clk), .rst(rst), .start_vld(start_vld), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .prot_bp(prot_bp), .wen(wen), .rprot(rprot), .seg_rd_idx(seg_rd_idx),
    .seg_rd_data(seg_rd_data), .commit_vld(commit_vld), .commit_seg(commit_seg),
    .commit_data(commit_data), .dir_wr_ok(dir_wr_ok)
  );

  always_comb
    for (int k = 0; k < 16; k++) seg_rd_data[k*8 +: 8] = seg_mem[seg_rd_idx][k];

  task automatic check(input logic ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic session(input logic [8:0] a, input int n, input logic [1:0] bp,
                         input logic w, input logic rp, input logic exp_c,
                         input logic exp_d, input string rq);
    logic [7:0]   e [16];
    logic [127:0] ev;
    int p;
    for (int k = 0; k < 16; k++) e[k] = seg_mem[a[7:4]][k];
    p = int'(a[3:0]);
    @(negedge clk);
    start_vld = 1'b1; start_addr = a; prot_bp = bp; wen = w; rprot = rp;
    @(negedge clk);
    start_vld = 1'b0;
    // R13 dir_wr_ok set one cycle after start
    check(dir_wr_ok == exp_d, {rq, " R13 dir_wr_ok after start"}, 128'(dir_wr_ok), 128'(exp_d));
    for (int i = 0; i < n; i++) begin
      byte_vld  = 1'b1;
      byte_data = 8'(8'hA1 + i * 13 + int'(a[7:0]));
      e[p] = byte_data;
      p = (p + 1) % 16;
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
    end
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    check(commit_vld == exp_c, {rq, " commit_vld"}, 128'(commit_vld), 128'(exp_c));
    if (exp_c) begin
      for (int k = 0; k < 16; k++) ev[k*8 +: 8] = e[k];
      check(commit_seg == a[7:4], {rq, " R5 commit_seg"}, 128'(commit_seg), 128'(a[7:4]));
      check(commit_data == ev, {rq, " R2 R3 commit_data"}, commit_data, ev);
    end
    // R13 cleared after cs_rise
    check(dir_wr_ok == 1'b0, {rq, " R13 dir_wr_ok cleared"}, 128'(dir_wr_ok), 128'(0));
    @(negedge clk);
    // R5 single-cycle pulse
    check(commit_vld == 1'b0, {rq, " R5 single pulse"}, 128'(commit_vld), 128'(0));
  endtask

  task automatic t_reset;
    check(commit_vld == 1'b0, "R1 commit_vld", 128'(commit_vld), 128'(0));
    check(dir_wr_ok == 1'b0, "R1 dir_wr_ok", 128'(dir_wr_ok), 128'(0));
  endtask

  task automatic t_user;
    session(9'h023, 3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R3 R12 partial");
    session(9'h0F0, 1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R2 single byte");
    session(9'h05E, 20, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R4 wrap");
    session(9'h040, 0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R6 no bytes");
    session(9'h031, 2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 wen low");
  endtask

  task automatic t_lock;
    session(9'h0C0, 2, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R8 bp01 seg12");
    session(9'h0B5, 2, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, "R8 bp01 seg11");
    session(9'h080, 2, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R8 bp10 seg8");
    session(9'h07F, 2, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R8 bp10 seg7");
    session(9'h000, 2, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R8 bp11 seg0");
  endtask

  task automatic t_direct;
    session(9'h105, 2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, "R9 cfg wen1");
    session(9'h10F, 1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R9 cfg wen0");
    session(9'h110, 1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R10 rom low");
    session(9'h11F, 1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R10 rom high");
    session(9'h136, 1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R10 unmapped");
    session(9'h1FF, 1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R10 top");
    session(9'h120, 1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R11 vol open");
    session(9'h135, 1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R11 vol last");
    session(9'h128, 1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R11 vol locked");
  endtask

  initial begin
    for (int s = 0; s < 16; s++)
      for (int b = 0; b < 16; b++) seg_mem[s][b] = 8'((s * 16 + b) ^ 8'h5A);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_user();
    t_lock();
    t_direct();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule